// File: doc/BRIEF.md
# UART channel status flag logic

This block holds the status word of one UART channel. The receiver, the transmitter, a receive-timeout counter, a modem-line monitor and two DMA channels each report single-cycle event pulses or levels to it. The block turns them into a 32-bit read-only word in which the low eleven positions carry flags and the rest read zero. It also drives one interrupt line, which is the OR of the flags that a mask input enables. The shift engines, the baud generator and the bus decode sit outside the block. A bus read simply samples `status`.

Three small state machines track the parts of the channel that have lifetimes. The receive machine has states RX_OFF, RX_EMPTY and RX_FULL. Its transitions are: enable (RX_OFF→RX_EMPTY), load (RX_EMPTY→RX_FULL, and RX_FULL→RX_FULL with overrun), read (RX_FULL→RX_EMPTY) and disable (any state→RX_OFF). The transmit machine has states TX_OFF, TX_IDLE, TX_SHIFT and TX_HELD. Its transitions are: enable (TX_OFF→TX_IDLE), write (TX_IDLE or TX_SHIFT→TX_HELD), load (TX_HELD→TX_SHIFT, or TX_HELD→TX_HELD when a write arrives in the same cycle), shift-done (TX_SHIFT→TX_IDLE) and disable (any state→TX_OFF). The timeout machine has states TO_IDLE, TO_ARMED and TO_FIRED. Its transitions are: start (any state→TO_ARMED) and expire (TO_ARMED→TO_FIRED when the programmed value is non-zero). The error and event flags are sticky bits that only the reset-status command clears.

Top module: `uart_chan_status`

## Requirements
- R1: Flag positions are: 0 receive-ready, 1 transmit-ready, 2 break, 3 receive-DMA-end, 4 transmit-DMA-end, 5 overrun, 6 framing, 7 parity, 8 timeout, 9 transmit-empty, 10 modem-change. Bits 31..11 always read 0. After reset, with both DMA end inputs high, the word reads 0x18.
- R2: Receive-ready (bit 0) sets when `rx_load` pulses while the receiver is enabled and clears on `rhr_read`. If both arrive in the same cycle it stays set. `rx_load` is ignored while the receiver is disabled, and the receiver is disabled after reset.
- R3: `rx_dis_cmd` clears bit 0 and disables the receiver. If it arrives together with `rx_en_cmd` or `rx_load`, the disable wins.
- R4: Overrun (bit 5) sets when `rx_load` arrives while bit 0 is already 1.
- R5: Framing (bit 6) sets on `rx_stop_low`.
- R6: Parity (bit 7) sets on `rx_par_chk`. With `multidrop`=0 this happens when `rx_par_bad`=1. With `multidrop`=1 it happens when `rx_par_val`=1.
- R7: Break (bit 2) sets on `rx_brk_edge`, which marks both the start and the end of a break.
- R8: Bits 2, 5, 6, 7 and 10 hold until `rst_sta_cmd`. A set event in the same cycle as that command leaves the bit set.
- R9: Transmit-ready (bit 1) is 0 in TX_OFF and in TX_HELD, and 1 in TX_IDLE and TX_SHIFT unless `tx_brk_pending`=1. `tx_dis_cmd` wins over every other transmit input.
- R10: Transmit-empty (bit 9) is 1 only in TX_IDLE. `tx_shift_done` moves TX_SHIFT to TX_IDLE.
- R11: Timeout (bit 8) sets on `to_expire` only in TO_ARMED with `to_zero`=0. `to_start` clears it and arms the counter, except that an expiry that counts in the same cycle wins.
- R12: Bits 3 and 4 follow `dma_rx_end` and `dma_tx_end` in the same cycle, with no latching.
- R13: Modem-change (bit 10) sets on `ms_change`.
- R14: `irq` is 1 exactly when some bit of `status & irq_mask` is 1, including the DMA bits in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en_cmd | input | 1 | Receiver enable command pulse |
| rx_dis_cmd | input | 1 | Receiver disable command pulse |
| rx_load | input | 1 | Character moved into receive holding register |
| rhr_read | input | 1 | Receive holding register read |
| rx_stop_low | input | 1 | Stop bit sampled low |
| rx_par_chk | input | 1 | Parity bit sampled this cycle |
| rx_par_bad | input | 1 | Parity mismatch, valid with rx_par_chk |
| rx_par_val | input | 1 | Sampled parity bit value |
| multidrop | input | 1 | Multidrop parity mode level |
| rx_brk_edge | input | 1 | Break start or end detected |
| to_start | input | 1 | Start-timeout command |
| to_expire | input | 1 | Timeout counter expiry |
| to_zero | input | 1 | Programmed timeout value is zero |
| tx_en_cmd | input | 1 | Transmitter enable command |
| tx_dis_cmd | input | 1 | Transmitter disable command |
| thr_write | input | 1 | Transmit holding register written |
| tx_load | input | 1 | Held character moved to shift register |
| tx_shift_done | input | 1 | Shift register finished its character |
| tx_brk_pending | input | 1 | Break request waiting for the shifter |
| ms_change | input | 1 | Modem input change detected |
| rst_sta_cmd | input | 1 | Reset-status command |
| dma_rx_end | input | 1 | Receive DMA end-of-transfer level |
| dma_tx_end | input | 1 | Transmit DMA end-of-transfer level |
| irq_mask | input | STAT_W | Interrupt enable per status bit |
| status | output | STAT_W | Status word |
| irq | output | 1 | Masked interrupt |

## Verification
The bench aims at same-cycle collisions. One case is a load with a read, where a design that lets the read win drops a received character. Another is an error event with the reset-status command, where a design that lets the clear win loses the error. A third is a load and a disable together, where a design that lets the disable lose leaves receive-ready stuck high on a disabled receiver. It also checks overrun only against the already-registered ready flag, the multidrop parity select, expiry that arrives before any start or while the timeout value is zero, and a write that meets a load in TX_HELD, where a wrong design would report transmit-ready while a character is still waiting.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;

    localparam int BIT_RX_RDY     = 0;
    localparam int BIT_TX_RDY     = 1;
    localparam int BIT_BRK        = 2;
    localparam int BIT_DMA_RX_END = 3;
    localparam int BIT_DMA_TX_END = 4;
    localparam int BIT_OVERRUN    = 5;
    localparam int BIT_FRAMING    = 6;
    localparam int BIT_PARITY     = 7;
    localparam int BIT_TIMEOUT    = 8;
    localparam int BIT_TX_EMPTY   = 9;
    localparam int BIT_MS_CHG     = 10;
    localparam int USED_BITS      = 11;

    // sticky flag slots
    localparam int STK_BRK   = 0;
    localparam int STK_OVR   = 1;
    localparam int STK_FRM   = 2;
    localparam int STK_PAR   = 3;
    localparam int STK_MSC   = 4;
    localparam int NUM_STICKY = 5;

    typedef enum logic [1:0] {
        RX_OFF   = 2'd0,
        RX_EMPTY = 2'd1,
        RX_FULL  = 2'd2
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_OFF   = 2'd0,
        TX_IDLE  = 2'd1,
        TX_SHIFT = 2'd2,
        TX_HELD  = 2'd3
    } tx_state_t;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_ARMED = 2'd1,
        TO_FIRED = 2'd2
    } to_state_t;

endpackage

// File: rtl/uart_stat_rx.sv
module uart_stat_rx
    import uart_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_cmd,
    input  logic dis_cmd,
    input  logic load,
    input  logic read,
    output logic rdy,
    output logic ovr_evt
);

    rx_state_t state_q;
    rx_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_OFF: begin
                if (en_cmd) begin
                    state_d = RX_EMPTY;
                end
            end
            RX_EMPTY: begin
                if (load) begin
                    state_d = RX_FULL;
                end
            end
            RX_FULL: begin
                if (read && !load) begin
                    state_d = RX_EMPTY;
                end
            end
            default: state_d = RX_OFF;
        endcase
        if (dis_cmd) begin
            state_d = RX_OFF;
        end
    end

    always_comb begin
        rdy     = (state_q == RX_FULL);
        ovr_evt = (state_q == RX_FULL) && load;
    end

endmodule

// File: rtl/uart_stat_tx.sv
module uart_stat_tx
    import uart_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_cmd,
    input  logic dis_cmd,
    input  logic wr,
    input  logic load,
    input  logic done,
    input  logic brk_pend,
    output logic rdy,
    output logic empty
);

    tx_state_t state_q;
    tx_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_OFF: begin
                if (en_cmd) begin
                    state_d = TX_IDLE;
                end
            end
            TX_IDLE: begin
                if (wr) begin
                    state_d = TX_HELD;
                end
            end
            TX_SHIFT: begin
                if (wr) begin
                    state_d = TX_HELD;
                end else if (done) begin
                    state_d = TX_IDLE;
                end
            end
            TX_HELD: begin
                if (load && !wr) begin
                    state_d = TX_SHIFT;
                end
            end
            default: state_d = TX_OFF;
        endcase
        if (dis_cmd) begin
            state_d = TX_OFF;
        end
    end

    always_comb begin
        rdy   = ((state_q == TX_IDLE) || (state_q == TX_SHIFT)) && !brk_pend;
        empty = (state_q == TX_IDLE);
    end

endmodule

// File: rtl/uart_stat_tmo.sv
module uart_stat_tmo
    import uart_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic expire,
    input  logic zero,
    output logic flag
);

    to_state_t state_q;
    to_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TO_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TO_IDLE: begin
                if (start) begin
                    state_d = TO_ARMED;
                end
            end
            TO_ARMED: begin
                if (expire && !zero) begin
                    state_d = TO_FIRED;
                end
            end
            TO_FIRED: begin
                if (start) begin
                    state_d = TO_ARMED;
                end
            end
            default: state_d = TO_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q == TO_FIRED);
    end

endmodule

// File: rtl/uart_stat_sticky.sv
module uart_stat_sticky #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else if (set[i]) begin
                q[i] <= 1'b1;
            end else if (clr) begin
                q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uart_chan_status.sv
module uart_chan_status
    import uart_stat_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en_cmd,
    input  logic              rx_dis_cmd,
    input  logic              rx_load,
    input  logic              rhr_read,
    input  logic              rx_stop_low,
    input  logic              rx_par_chk,
    input  logic              rx_par_bad,
    input  logic              rx_par_val,
    input  logic              multidrop,
    input  logic              rx_brk_edge,
    input  logic              to_start,
    input  logic              to_expire,
    input  logic              to_zero,
    input  logic              tx_en_cmd,
    input  logic              tx_dis_cmd,
    input  logic              thr_write,
    input  logic              tx_load,
    input  logic              tx_shift_done,
    input  logic              tx_brk_pending,
    input  logic              ms_change,
    input  logic              rst_sta_cmd,
    input  logic              dma_rx_end,
    input  logic              dma_tx_end,
    input  logic [STAT_W-1:0] irq_mask,
    output logic [STAT_W-1:0] status,
    output logic              irq
);

    localparam int PAD_W = STAT_W - USED_BITS;

    logic                  rx_rdy;
    logic                  rx_ovr_evt;
    logic                  tx_rdy;
    logic                  tx_empty;
    logic                  to_flag;
    logic                  par_evt;
    logic [NUM_STICKY-1:0] stk_set;
    logic [NUM_STICKY-1:0] stk_q;
    logic [USED_BITS-1:0]  flags;

    uart_stat_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_cmd  (rx_en_cmd),
        .dis_cmd (rx_dis_cmd),
        .load    (rx_load),
        .read    (rhr_read),
        .rdy     (rx_rdy),
        .ovr_evt (rx_ovr_evt)
    );

    uart_stat_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_cmd   (tx_en_cmd),
        .dis_cmd  (tx_dis_cmd),
        .wr       (thr_write),
        .load     (tx_load),
        .done     (tx_shift_done),
        .brk_pend (tx_brk_pending),
        .rdy      (tx_rdy),
        .empty    (tx_empty)
    );

    uart_stat_tmo u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (to_start),
        .expire (to_expire),
        .zero   (to_zero),
        .flag   (to_flag)
    );

    always_comb begin
        par_evt = rx_par_chk && (multidrop ? rx_par_val : rx_par_bad);
        stk_set          = '0;
        stk_set[STK_BRK] = rx_brk_edge;
        stk_set[STK_OVR] = rx_ovr_evt;
        stk_set[STK_FRM] = rx_stop_low;
        stk_set[STK_PAR] = par_evt;
        stk_set[STK_MSC] = ms_change;
    end

    uart_stat_sticky #(
        .N (NUM_STICKY)
    ) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (stk_set),
        .clr   (rst_sta_cmd),
        .q     (stk_q)
    );

    always_comb begin
        flags                 = '0;
        flags[BIT_RX_RDY]     = rx_rdy;
        flags[BIT_TX_RDY]     = tx_rdy;
        flags[BIT_BRK]        = stk_q[STK_BRK];
        flags[BIT_DMA_RX_END] = dma_rx_end;
        flags[BIT_DMA_TX_END] = dma_tx_end;
        flags[BIT_OVERRUN]    = stk_q[STK_OVR];
        flags[BIT_FRAMING]    = stk_q[STK_FRM];
        flags[BIT_PARITY]     = stk_q[STK_PAR];
        flags[BIT_TIMEOUT]    = to_flag;
        flags[BIT_TX_EMPTY]   = tx_empty;
        flags[BIT_MS_CHG]     = stk_q[STK_MSC];
    end

    assign status = {{PAD_W{1'b0}}, flags};
    assign irq    = |(status & irq_mask);

endmodule

// File: rtl/uart_chan_status_chk.sv
module uart_chan_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_load,
    input logic        rx_dis_cmd,
    input logic        rx_stop_low,
    input logic        rst_sta_cmd,
    input logic        tx_en_cmd,
    input logic        tx_dis_cmd,
    input logic        thr_write,
    input logic        ms_change,
    input logic        to_zero,
    input logic [10:0] st
);

    p_rxrdy_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st[0] && rx_load && !rx_dis_cmd) |=> st[0]);

    p_rxdis_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dis_cmd |=> !st[0]);

    p_overrun_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st[0] && rx_load) |=> st[5]);

    p_framing_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stop_low |=> st[6]);

    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st[6] && !rst_sta_cmd) |=> st[6]);

    p_txoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dis_cmd |=> (!st[1] && !st[9]));

    p_txwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_write && !tx_en_cmd) |=> !st[1]);

    p_tozero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (to_zero && !st[8]) |=> !st[8]);

    p_modem_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ms_change |=> st[10]);

endmodule

bind uart_chan_status uart_chan_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_load     (rx_load),
    .rx_dis_cmd  (rx_dis_cmd),
    .rx_stop_low (rx_stop_low),
    .rst_sta_cmd (rst_sta_cmd),
    .tx_en_cmd   (tx_en_cmd),
    .tx_dis_cmd  (tx_dis_cmd),
    .thr_write   (thr_write),
    .ms_change   (ms_change),
    .to_zero     (to_zero),
    .st          (status[10:0])
);

// File: tb/uart_chan_status_test.sv
`timescale 1ns/1ps
module uart_chan_status_test;

    localparam int W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en_cmd, rx_dis_cmd, rx_load, rhr_read, rx_stop_low;
    logic rx_par_chk, rx_par_bad, rx_par_val, multidrop, rx_brk_edge;
    logic to_start, to_expire, to_zero;
    logic tx_en_cmd, tx_dis_cmd, thr_write, tx_load, tx_shift_done, tx_brk_pending;
    logic ms_change, rst_sta_cmd, dma_rx_end, dma_tx_end;
    logic [W-1:0] irq_mask;
    logic [W-1:0] status;
    logic irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    uart_chan_status #(.STAT_W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .rx_en_cmd(rx_en_cmd), .rx_dis_cmd(rx_dis_cmd), .rx_load(rx_load),
        .rhr_read(rhr_read), .rx_stop_low(rx_stop_low), .rx_par_chk(rx_par_chk),
        .rx_par_bad(rx_par_bad), .rx_par_val(rx_par_val), .multidrop(multidrop),
        .rx_brk_edge(rx_brk_edge), .to_start(to_start), .to_expire(to_expire),
        .to_zero(to_zero), .tx_en_cmd(tx_en_cmd), .tx_dis_cmd(tx_dis_cmd),
        .thr_write(thr_write), .tx_load(tx_load), .tx_shift_done(tx_shift_done),
        .tx_brk_pending(tx_brk_pending), .ms_change(ms_change),
        .rst_sta_cmd(rst_sta_cmd), .dma_rx_end(dma_rx_end), .dma_tx_end(dma_tx_end),
        .irq_mask(irq_mask), .status(status), .irq(irq)
    );

    // behavioural reference: integers for machine phases
    int m_rx_on, m_rxrdy, m_ovr, m_frm, m_par, m_brk, m_msc;
    int m_tx;   // 0 off, 1 idle, 2 shifting, 3 holding
    int m_to;   // 0 never started, 1 waiting, 2 expired

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rx_on = 0; m_rxrdy = 0; m_ovr = 0; m_frm = 0; m_par = 0;
            m_brk = 0; m_msc = 0; m_tx = 0; m_to = 0;
        end else begin
            int n_on, n_rdy, n_tx, n_to;
            bit pev;
            pev = rx_par_chk && (multidrop ? rx_par_val : rx_par_bad);
            // sticky: set beats clear
            if (m_rxrdy == 1 && rx_load) m_ovr = 1; else if (rst_sta_cmd) m_ovr = 0;
            if (rx_stop_low) m_frm = 1; else if (rst_sta_cmd) m_frm = 0;
            if (pev) m_par = 1; else if (rst_sta_cmd) m_par = 0;
            if (rx_brk_edge) m_brk = 1; else if (rst_sta_cmd) m_brk = 0;
            if (ms_change) m_msc = 1; else if (rst_sta_cmd) m_msc = 0;
            // receiver
            n_on = m_rx_on; n_rdy = m_rxrdy;
            if (rx_dis_cmd) begin n_on = 0; n_rdy = 0; end
            else if (m_rx_on == 0) begin if (rx_en_cmd) n_on = 1; end
            else if (rx_load) n_rdy = 1;
            else if (rhr_read) n_rdy = 0;
            m_rx_on = n_on; m_rxrdy = n_rdy;
            // transmitter
            n_tx = m_tx;
            if (tx_dis_cmd) n_tx = 0;
            else if (m_tx == 0) begin if (tx_en_cmd) n_tx = 1; end
            else if (m_tx == 1) begin if (thr_write) n_tx = 3; end
            else if (m_tx == 2) begin
                if (thr_write) n_tx = 3; else if (tx_shift_done) n_tx = 1;
            end
            else begin if (tx_load && !thr_write) n_tx = 2; end
            m_tx = n_tx;
            // timeout
            n_to = m_to;
            if (m_to == 1 && to_expire && !to_zero) n_to = 2;
            else if (to_start) n_to = 1;
            m_to = n_to;
        end
    end

    function automatic logic [W-1:0] model_word();
        logic [W-1:0] e = '0;
        e[0]  = (m_rxrdy == 1);
        e[1]  = (m_tx == 1 || m_tx == 2) && !tx_brk_pending;
        e[2]  = (m_brk == 1);
        e[3]  = dma_rx_end;
        e[4]  = dma_tx_end;
        e[5]  = (m_ovr == 1);
        e[6]  = (m_frm == 1);
        e[7]  = (m_par == 1);
        e[8]  = (m_to == 2);
        e[9]  = (m_tx == 1);
        e[10] = (m_msc == 1);
        return e;
    endfunction

    function automatic string req_of(int b);
        case (b)
            0: return "R2";
            1: return "R9";
            2: return "R7";
            3, 4: return "R12";
            5: return "R4";
            6: return "R5";
            7: return "R6";
            8: return "R11";
            9: return "R10";
            10: return "R13";
            default: return "R1";
        endcase
    endfunction

    task automatic compare_all();
        logic [W-1:0] e;
        logic ei;
        e = model_word();
        ei = |(e & irq_mask);
        total++;
        if (status !== e) begin
            bad++;
            for (int b = 0; b < W; b++)
                if (status[b] !== e[b]) begin
                    $display("FAIL %s bit %0d: status=%h expected=%h", req_of(b), b, status, e);
                    break;
                end
        end
        total++;
        if (irq !== ei) begin
            bad++;
            $display("FAIL R14 irq=%b expected=%b", irq, ei);
        end
    endtask

    task automatic want(int b, logic v, string req);
        total++;
        if (status[b] !== v) begin
            bad++;
            $display("FAIL %s bit %0d actual=%b expected=%b", req, b, status[b], v);
        end
    endtask

    task automatic clear_pulses();
        rx_en_cmd = 0; rx_dis_cmd = 0; rx_load = 0; rhr_read = 0; rx_stop_low = 0;
        rx_par_chk = 0; rx_brk_edge = 0; to_start = 0; to_expire = 0;
        tx_en_cmd = 0; tx_dis_cmd = 0; thr_write = 0; tx_load = 0; tx_shift_done = 0;
        ms_change = 0; rst_sta_cmd = 0;
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
        clear_pulses();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear_pulses();
        rx_par_bad = 0; rx_par_val = 0; multidrop = 0; to_zero = 0;
        tx_brk_pending = 0; dma_rx_end = 1; dma_tx_end = 1; irq_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        total++;
        if (status !== 32'h18) begin
            bad++;
            $display("FAIL R1 reset word actual=%h expected=%h", status, 32'h18);
        end
        // R12 DMA levels pass through in the same cycle
        dma_rx_end = 0; #1; want(3, 0, "R12");
        dma_tx_end = 0; #1; want(4, 0, "R12");
        // R2 load ignored while receiver off
        rx_load = 1; step(); want(0, 0, "R2");
        rx_en_cmd = 1; step();
        rx_load = 1; step(); want(0, 1, "R2");
        want(5, 0, "R4");
        rx_load = 1; step(); want(5, 1, "R4");
        rx_load = 1; rhr_read = 1; step(); want(0, 1, "R2");
        rhr_read = 1; step(); want(0, 0, "R2");
        // R3 disable beats load, and disable beats enable
        rx_load = 1; rx_dis_cmd = 1; step(); want(0, 0, "R3");
        rx_en_cmd = 1; rx_dis_cmd = 1; step();
        rx_load = 1; step(); want(0, 0, "R3");
        // R5, R6, R7, R13
        rx_stop_low = 1; step(); want(6, 1, "R5");
        rst_sta_cmd = 1; step(); want(5, 0, "R8"); want(6, 0, "R8");
        rx_par_chk = 1; rx_par_val = 1; rx_par_bad = 0; step(); want(7, 0, "R6");
        rx_par_chk = 1; rx_par_bad = 1; step(); want(7, 1, "R6");
        rst_sta_cmd = 1; step();
        multidrop = 1;
        rx_par_chk = 1; rx_par_val = 0; rx_par_bad = 1; step(); want(7, 0, "R6");
        rx_par_chk = 1; rx_par_val = 1; rx_par_bad = 0; step(); want(7, 1, "R6");
        multidrop = 0;
        rx_brk_edge = 1; step(); want(2, 1, "R7");
        ms_change = 1; step(); want(10, 1, "R13");
        // R8 set beats clear in the same cycle
        rst_sta_cmd = 1; rx_stop_low = 1; step(); want(6, 1, "R8"); want(2, 0, "R8");
        rst_sta_cmd = 1; step(); want(6, 0, "R8");
        // R9, R10 transmitter
        want(1, 0, "R9");
        tx_en_cmd = 1; step(); want(1, 1, "R9"); want(9, 1, "R10");
        thr_write = 1; step(); want(1, 0, "R9"); want(9, 0, "R10");
        tx_load = 1; thr_write = 1; step(); want(1, 0, "R9");
        tx_load = 1; step(); want(1, 1, "R9"); want(9, 0, "R10");
        tx_shift_done = 1; step(); want(9, 1, "R10");
        tx_brk_pending = 1; #1; want(1, 0, "R9");
        tx_brk_pending = 0;
        tx_dis_cmd = 1; tx_en_cmd = 1; step(); want(1, 0, "R9"); want(9, 0, "R10");
        // R11 timeout
        to_expire = 1; step(); want(8, 0, "R11");
        to_start = 1; step();
        to_expire = 1; step(); want(8, 1, "R11");
        to_start = 1; step(); want(8, 0, "R11");
        to_zero = 1; to_expire = 1; step(); want(8, 0, "R11");
        to_zero = 0;
        to_start = 1; to_expire = 1; step(); want(8, 1, "R11");
        // R14 masking
        irq_mask = 32'h100; step();
        total++;
        if (irq !== 1'b1) begin bad++; $display("FAIL R14 irq=%b expected=1", irq); end
        irq_mask = 32'h001; step();
        total++;
        if (irq !== 1'b0) begin bad++; $display("FAIL R14 irq=%b expected=0", irq); end
        // mixed random traffic compared each clock
        for (int i = 0; i < 4000; i++) begin
            rx_en_cmd = ($urandom % 10) == 0; rx_dis_cmd = ($urandom % 25) == 0;
            rx_load = ($urandom % 4) == 0; rhr_read = ($urandom % 4) == 0;
            rx_stop_low = ($urandom % 20) == 0; rx_par_chk = ($urandom % 6) == 0;
            rx_par_bad = $urandom % 2; rx_par_val = $urandom % 2;
            if (($urandom % 50) == 0) multidrop = ~multidrop;
            rx_brk_edge = ($urandom % 30) == 0;
            to_start = ($urandom % 12) == 0; to_expire = ($urandom % 5) == 0;
            if (($urandom % 40) == 0) to_zero = ~to_zero;
            tx_en_cmd = ($urandom % 10) == 0; tx_dis_cmd = ($urandom % 30) == 0;
            thr_write = ($urandom % 4) == 0; tx_load = ($urandom % 3) == 0;
            tx_shift_done = ($urandom % 3) == 0;
            tx_brk_pending = ($urandom % 8) == 0;
            ms_change = ($urandom % 30) == 0; rst_sta_cmd = ($urandom % 15) == 0;
            dma_rx_end = $urandom % 2; dma_tx_end = $urandom % 2;
            irq_mask = W'($urandom) & W'($urandom);
            step();
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule